// File: doc/BRIEF.md
# Configurable Packet Gather/Scatter Engine

This block joins a byte-wide packet stream to two banks of byte registers: a bank of input registers that the engine samples, and a bank of output registers that it holds. The link carries only the registers that are in use. A setup packet names them. It gives a count of registers to sample, then a count of registers to update, then the addresses of those registers in sequence. The engine keeps that layout until a later setup packet that passes its checks replaces it.

After setup, a short request packet makes the engine stream the selected input registers back, one byte per listed address, in list order. An update packet carries one data byte per listed output address. The engine places each byte into the register that the matching list slot names, and it applies the whole packet at once when the last byte arrives. Both streams use a valid/ready handshake with start-of-packet and end-of-packet flags. The first byte of every incoming packet selects what kind of packet it is.

Top module: `gse_engine`

## Requirements
- R1: After reset, out_valid is 0, every output register reads 0x00, no layout is active, and in_ready is 1.
- R2: The byte that carries in_sop selects the packet kind: 0x01 is setup, 0x02 is update, 0x03 is sample request. Any other value, and any byte that arrives outside a packet, is dropped without effect. A new in_sop abandons an unfinished packet, which then has no effect.
- R3: The payload of a setup packet is the sample count Nr, then the update count Nw, then Nr sample addresses, then Nw update addresses. The packet is taken only if the payload holds exactly Nr+Nw+2 bytes and both counts are at most MAX_LIST. Otherwise the layout that was active stays active.
- R4: A sample request under an active layout with Nr>0 produces exactly Nr output bytes. out_sop is set on the first byte and out_eop on the last. Byte i equals the input register named by sample-list slot i. An address of N_RD_REGS or above yields 0x00.
- R5: A sample request produces no output while no layout has been taken, or while the active layout has Nr=0.
- R6: While out_ready is 0, out_valid stays 1 and the same byte position (out_sop/out_eop) stays presented.
- R7: An update packet whose payload length equals Nw writes payload byte i into the output register named by update-list slot i. Addresses of N_WR_REGS or above are skipped. When two slots name the same register, the later slot wins.
- R8: An update packet whose payload length differs from Nw, or any update packet that arrives before a layout is taken, changes no output register.
- R9: All writes of one update packet become visible together, in the cycle after its last byte is accepted, and not earlier.
- R10: A layout that has been taken serves every later request and update until another setup packet is taken. Sampled values follow the current contents of the input registers.
- R11: A sample request that arrives while an output packet is still streaming is ignored. No second packet is started.
- R12: Update packets are accepted and applied while an output packet streams, without disturbing it. The last byte of a setup packet is held off (in_ready low) until the stream ends. in_ready is 1 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Engine accepts the incoming byte |
| in_data | input | 8 | Incoming byte |
| in_sop | input | 1 | Incoming byte is the first of a packet (the kind byte) |
| in_eop | input | 1 | Incoming byte is the last of a packet |
| rd_regs | input | N_RD_REGS*8 | Input register bank; register r at bits r*8+7:r*8 |
| wr_regs | output | N_WR_REGS*8 | Output register bank; register r at bits r*8+7:r*8 |
| out_valid | output | 1 | Outgoing byte is valid |
| out_ready | input | 1 | Receiver takes the outgoing byte |
| out_data | output | 8 | Outgoing byte |
| out_sop | output | 1 | Outgoing byte is the first of the packet |
| out_eop | output | 1 | Outgoing byte is the last of the packet |

## Verification
An update packet can finish in the same cycle in which the engine is presenting a sampled byte. A setup packet can end while a stream is still open. The bench provokes both by holding out_ready low after a request. During that hold it sends a second request, a full update packet and then a setup packet. It judges the result by three things: the held stream must come out as exactly the original layout's bytes, once; the update must show in the output registers while the stream is still stalled; and in_ready must be low on the setup packet's last byte until the stream drains, after which the new layout serves the next request.

// File: rtl/gse_pkg.sv
package gse_pkg;
  localparam logic [7:0] KIND_SETUP  = 8'h01;
  localparam logic [7:0] KIND_UPDATE = 8'h02;
  localparam logic [7:0] KIND_SAMPLE = 8'h03;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_SETUP,
    PS_UPDATE,
    PS_SAMPLE,
    PS_DROP
  } pstate_e;
endpackage

// File: rtl/gse_cfg_store.sv
module gse_cfg_store #(
  parameter int MAX_LIST = 8,
  parameter int LEN_W    = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             load_nr,
  input  logic                             load_nw,
  input  logic                             load_addr,
  input  logic [$clog2(2*MAX_LIST)-1:0]    slot,
  input  logic [7:0]                       din,
  input  logic                             fin,
  input  logic [LEN_W-1:0]                 fin_len,
  output logic                             cfg_valid,
  output logic [7:0]                       cfg_nr,
  output logic [7:0]                       cfg_nw,
  output logic [2*MAX_LIST-1:0][7:0]       cfg_list
);
  localparam int LIST_N = 2 * MAX_LIST;

  logic [7:0]              st_nr_q, st_nw_q, eff_nr, eff_nw;
  logic [LIST_N-1:0][7:0]  st_list_q, eff_list;
  logic [7:0]              act_nr_q, act_nw_q;
  logic [LIST_N-1:0][7:0]  act_list_q;
  logic                    valid_q, take;
  logic [9:0]              need;

  // staged values, with bypass of the byte arriving this cycle
  always_comb begin
    eff_nr = load_nr ? din : st_nr_q;
    eff_nw = load_nw ? din : st_nw_q;
    for (int s = 0; s < LIST_N; s++) begin
      eff_list[s] = (load_addr && (slot == $clog2(LIST_N)'(s))) ? din : st_list_q[s];
    end
    need = {2'b00, eff_nr} + {2'b00, eff_nw} + 10'd2;
    take = fin && (10'(fin_len) == need) &&
           (eff_nr <= 8'(MAX_LIST)) && (eff_nw <= 8'(MAX_LIST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_nr_q   <= '0;
      st_nw_q   <= '0;
      st_list_q <= '0;
    end else begin
      if (load_nr) st_nr_q <= din;
      if (load_nw) st_nw_q <= din;
      if (load_addr) st_list_q <= eff_list;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_nr_q   <= '0;
      act_nw_q   <= '0;
      act_list_q <= '0;
      valid_q    <= 1'b0;
    end else if (take) begin
      act_nr_q   <= eff_nr;
      act_nw_q   <= eff_nw;
      act_list_q <= eff_list;
      valid_q    <= 1'b1;
    end
  end

  assign cfg_valid = valid_q;
  assign cfg_nr    = act_nr_q;
  assign cfg_nw    = act_nw_q;
  assign cfg_list  = act_list_q;

  AST_COUNTS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_nr <= 8'(MAX_LIST)) && (cfg_nw <= 8'(MAX_LIST)));  // R3
endmodule

// File: rtl/gse_wr_bank.sv
module gse_wr_bank #(
  parameter int MAX_LIST  = 8,
  parameter int N_WR_REGS = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             stage_en,
  input  logic [$clog2(MAX_LIST)-1:0]      stage_idx,
  input  logic [7:0]                       din,
  input  logic                             commit,
  input  logic [7:0]                       nw,
  input  logic [MAX_LIST-1:0][7:0]         waddr,
  output logic [N_WR_REGS*8-1:0]           wr_regs
);
  localparam int STAGE_W = $clog2(MAX_LIST);

  logic [MAX_LIST-1:0][7:0]  stage_q, stage_d, wval;
  logic [N_WR_REGS-1:0][7:0] bank_q, bank_d;

  always_comb begin
    stage_d = stage_q;
    for (int i = 0; i < MAX_LIST; i++) begin
      wval[i] = (stage_en && (stage_idx == STAGE_W'(i))) ? din : stage_q[i];
    end
    if (stage_en) stage_d = wval;
  end

  // later slots override earlier ones on the same register
  always_comb begin
    bank_d = bank_q;
    for (int r = 0; r < N_WR_REGS; r++) begin
      for (int i = 0; i < MAX_LIST; i++) begin
        if (commit && (8'(i) < nw) && (waddr[i] == 8'(r))) bank_d[r] = wval[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      bank_q  <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (commit)   bank_q  <= bank_d;
    end
  end

  assign wr_regs = bank_q;

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(wr_regs));  // R8
endmodule

// File: rtl/gse_rd_gather.sv
module gse_rd_gather #(
  parameter int MAX_LIST  = 8,
  parameter int N_RD_REGS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        cfg_valid,
  input  logic [7:0]                  nr,
  input  logic [MAX_LIST-1:0][7:0]    rlist,
  input  logic [N_RD_REGS*8-1:0]      rd_regs,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [7:0]                  out_data,
  output logic                        out_sop,
  output logic                        out_eop,
  output logic                        busy
);
  localparam int IDX_W = $clog2(MAX_LIST);

  logic             busy_q, busy_d, last, hs;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       addr;

  assign last = ({{(8-IDX_W){1'b0}}, idx_q} == (nr - 8'd1));
  assign hs   = busy_q && out_ready;
  assign addr = rlist[idx_q];

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (!busy_q) begin
      if (start && cfg_valid && (nr != 8'd0)) begin
        busy_d = 1'b1;
        idx_d  = '0;
      end
    end else if (hs) begin
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_comb begin
    out_data = 8'h00;
    for (int r = 0; r < N_RD_REGS; r++) begin
      if (addr == 8'(r)) out_data = rd_regs[r*8 +: 8];
    end
  end

  assign out_valid = busy_q;
  assign out_sop   = busy_q && (idx_q == '0);
  assign out_eop   = busy_q && last;
  assign busy      = busy_q;

  AST_NO_OUT_UNCFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> !out_valid);  // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_sop) && $stable(out_eop));  // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop && start && !(out_ready && out_eop)) |=> !out_sop);  // R11
endmodule

// File: rtl/gse_engine.sv
module gse_engine #(
  parameter int N_RD_REGS = 16,
  parameter int N_WR_REGS = 16,
  parameter int MAX_LIST  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [7:0]               in_data,
  input  logic                     in_sop,
  input  logic                     in_eop,
  input  logic [N_RD_REGS*8-1:0]   rd_regs,
  output logic [N_WR_REGS*8-1:0]   wr_regs,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [7:0]               out_data,
  output logic                     out_sop,
  output logic                     out_eop
);
  import gse_pkg::*;

  localparam int LIST_N  = 2 * MAX_LIST;
  localparam int SLOT_W  = $clog2(LIST_N);
  localparam int STAGE_W = $clog2(MAX_LIST);
  localparam int LEN_W   = $clog2(LIST_N + 3) + 1;

  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pstate_e              st_q, st_d, cur_t;
  logic [LEN_W-1:0]     len_q, len_d, len_inc, this_len;
  logic                 acc, pay, rd_busy;
  logic                 cfg_valid;
  logic [7:0]           cfg_nr, cfg_nw;
  logic [LIST_N-1:0][7:0]   cfg_list;
  logic [MAX_LIST-1:0][7:0] waddr;
  logic                 load_nr, load_nw, load_addr, cfg_fin;
  logic                 stage_en, commit, rd_req;

  always_comb begin
    if (in_sop) begin
      case (in_data)
        KIND_SETUP:  cur_t = PS_SETUP;
        KIND_UPDATE: cur_t = PS_UPDATE;
        KIND_SAMPLE: cur_t = PS_SAMPLE;
        default:     cur_t = PS_DROP;
      endcase
    end else begin
      cur_t = st_q;
    end
  end

  // a setup packet may not finish while a stream still reads the list
  assign in_ready = !(rd_busy && in_valid && in_eop && (cur_t == PS_SETUP));
  assign acc      = in_valid && in_ready;
  assign pay      = acc && !in_sop;
  assign len_inc  = (len_q == '1) ? len_q : len_q + LEN_W'(1);
  assign this_len = in_sop ? '0 : len_inc;

  always_comb begin
    st_d  = st_q;
    len_d = len_q;
    if (acc) begin
      st_d  = in_eop ? PS_IDLE : cur_t;
      len_d = in_eop ? '0 : this_len;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= PS_IDLE;
      len_q <= '0;
    end else if (acc) begin
      st_q  <= st_d;
      len_q <= len_d;
    end
  end

  // payload steering
  assign load_nr   = pay && (st_q == PS_SETUP) && (len_q == LEN_W'(0));
  assign load_nw   = pay && (st_q == PS_SETUP) && (len_q == LEN_W'(1));
  assign load_addr = pay && (st_q == PS_SETUP) && (len_q >= LEN_W'(2)) &&
                     ((len_q - LEN_W'(2)) < LEN_W'(LIST_N));
  assign cfg_fin   = acc && in_eop && (cur_t == PS_SETUP);
  assign stage_en  = pay && (st_q == PS_UPDATE) && (len_q < LEN_W'(MAX_LIST));
  assign commit    = acc && in_eop && (cur_t == PS_UPDATE) && cfg_valid &&
                     (this_len == LEN_W'(cfg_nw));
  assign rd_req    = acc && in_eop && (cur_t == PS_SAMPLE);

  // update slots follow the sample slots in the stored list
  for (genvar i = 0; i < MAX_LIST; i++) begin : g_waddr
    assign waddr[i] = cfg_list[SLOT_W'(cfg_nr) + SLOT_W'(i)];
  end

  gse_cfg_store #(.MAX_LIST(MAX_LIST), .LEN_W(LEN_W)) cfg_i (
    .clk(clk), .rst_n(rst_sync_n),
    .load_nr(load_nr), .load_nw(load_nw), .load_addr(load_addr),
    .slot(SLOT_W'(len_q - LEN_W'(2))), .din(in_data),
    .fin(cfg_fin), .fin_len(this_len),
    .cfg_valid(cfg_valid), .cfg_nr(cfg_nr), .cfg_nw(cfg_nw), .cfg_list(cfg_list)
  );

  gse_wr_bank #(.MAX_LIST(MAX_LIST), .N_WR_REGS(N_WR_REGS)) bank_i (
    .clk(clk), .rst_n(rst_sync_n),
    .stage_en(stage_en), .stage_idx(len_q[STAGE_W-1:0]), .din(in_data),
    .commit(commit), .nw(cfg_nw), .waddr(waddr), .wr_regs(wr_regs)
  );

  gse_rd_gather #(.MAX_LIST(MAX_LIST), .N_RD_REGS(N_RD_REGS)) gather_i (
    .clk(clk), .rst_n(rst_sync_n),
    .start(rd_req), .cfg_valid(cfg_valid), .nr(cfg_nr),
    .rlist(cfg_list[MAX_LIST-1:0]), .rd_regs(rd_regs), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .busy(rd_busy)
  );

  AST_LIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !(out_ready && out_eop)) |=> $stable(cfg_nr) && $stable(cfg_list));  // R12
  AST_LAYOUT_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_fin |=> $stable(cfg_nr) && $stable(cfg_nw) && $stable(cfg_valid));  // R10
endmodule

// File: tb/gse_engine_tb_top.sv
module gse_engine_tb_top;
  localparam int NRD = 16;
  localparam int NWR = 16;
  localparam int ML  = 8;

  logic clk, rst_n;
  logic in_valid, in_ready, in_sop, in_eop;
  logic [7:0] in_data;
  logic [NRD*8-1:0] rd_regs;
  logic [NWR*8-1:0] wr_regs, exp_wr;
  logic out_valid, out_ready, out_sop, out_eop;
  logic [7:0] out_data;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] rx_d[$];
  bit rx_s[$];
  bit rx_e[$];

  gse_engine #(.N_RD_REGS(NRD), .N_WR_REGS(NWR), .MAX_LIST(ML)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .rd_regs(rd_regs), .wr_regs(wr_regs),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      rx_d.push_back(out_data);
      rx_s.push_back(out_sop);
      rx_e.push_back(out_eop);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_wr(input string req);
    n_run++;
    if (wr_regs !== exp_wr) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, wr_regs, exp_wr);
    end
  endtask

  // called at posedge+2; returns at posedge+2 after acceptance
  task automatic put(input logic [7:0] b, input logic s, input logic e);
    logic r;
    in_valid = 1'b1; in_data = b; in_sop = s; in_eop = e;
    do begin
      @(negedge clk); r = in_ready;
      @(posedge clk); #2;
    end while (!r);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send(input logic [7:0] p[$]);
    for (int i = 0; i < p.size(); i++) put(p[i], i == 0, i == p.size() - 1);
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic clear_rx();
    rx_d.delete(); rx_s.delete(); rx_e.delete();
  endtask

  task automatic check_rx(input string req, input logic [7:0] exp[$]);
    chk({req, " byte count"}, rx_d.size(), exp.size());
    for (int i = 0; i < exp.size(); i++) begin
      if (i < rx_d.size()) begin
        chk({req, " data"}, rx_d[i], exp[i]);
        chk({req, " framing"}, {rx_s[i], rx_e[i]}, {i == 0, i == exp.size() - 1});
      end
    end
  endtask

  task automatic expect_read(input string req, input logic [7:0] exp[$]);
    clear_rx();
    send('{8'h03});
    repeat (exp.size() + 4) @(posedge clk);
    #2;
    check_rx(req, exp);
  endtask

  task automatic expect_none(input string req);
    clear_rx();
    send('{8'h03});
    repeat (6) @(posedge clk);
    #2;
    chk(req, rx_d.size(), 0);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk_wr("R1 output regs");
  endtask

  task automatic t_before_setup();
    expect_none("R5 request before setup");
    send('{8'h02, 8'hAA});
    chk_wr("R8 update before setup");
  endtask

  task automatic t_bad_setup();
    send('{8'h01, 8'd2, 8'd1, 8'd3, 8'd5});
    expect_none("R3 short setup rejected");
    send('{8'h01, 8'd9, 8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8, 8'd9});
    expect_none("R3 oversize count rejected");
  endtask

  task automatic t_setup_read();
    send('{8'h01, 8'd3, 8'd2, 8'd5, 8'd0, 8'd20, 8'd2, 8'd7});
    expect_read("R4 gather list order", '{8'h45, 8'h40, 8'h00});
  endtask

  task automatic t_update_atomic();
    put(8'h02, 1'b1, 1'b0);
    put(8'h11, 1'b0, 1'b0);
    in_valid = 1'b1; in_data = 8'h22; in_sop = 1'b0; in_eop = 1'b1;
    @(negedge clk);
    chk_wr("R9 nothing applied before last byte");
    @(posedge clk); #2;
    in_valid = 1'b0; in_eop = 1'b0;
    exp_wr[2*8 +: 8] = 8'h11;
    exp_wr[7*8 +: 8] = 8'h22;
    @(negedge clk);
    chk_wr("R7 R9 both writes applied together");
    @(posedge clk); #2;
  endtask

  task automatic t_update_wrong_len();
    send('{8'h02, 8'h33});
    chk_wr("R8 short update discarded");
    send('{8'h02, 8'h01, 8'h02, 8'h03});
    chk_wr("R8 long update discarded");
  endtask

  task automatic t_kind_and_abort();
    put(8'h02, 1'b1, 1'b0);
    put(8'h55, 1'b0, 1'b0);
    expect_read("R2 new sop abandons update", '{8'h45, 8'h40, 8'h00});
    chk_wr("R2 abandoned update has no effect");
    send('{8'h07, 8'h03, 8'h01});
    put(8'h03, 1'b0, 1'b1);
    chk("R2 unknown kind and stray byte", out_valid, 0);
    chk_wr("R2 unknown kind leaves registers");
  endtask

  task automatic t_reuse();
    send('{8'h01, 8'd1, 8'd0});
    expect_read("R10 layout kept after rejected setup", '{8'h45, 8'h40, 8'h00});
    rd_regs[5*8 +: 8] = 8'h99;
    expect_read("R10 layout reused with new values", '{8'h99, 8'h40, 8'h00});
    rd_regs[5*8 +: 8] = 8'h45;
  endtask

  task automatic t_backpressure();
    clear_rx();
    out_ready = 1'b0;
    send('{8'h03});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 held first byte", {out_valid, out_sop, out_eop}, 3'b110);
      @(posedge clk); #2;
    end
    out_ready = 1'b1;
    repeat (6) @(posedge clk);
    #2;
    check_rx("R6 stream after stall", '{8'h45, 8'h40, 8'h00});
  endtask

  task automatic t_overlap();
    logic r;
    clear_rx();
    out_ready = 1'b0;
    send('{8'h03});
    send('{8'h03});
    send('{8'h02, 8'h66, 8'h77});
    exp_wr[2*8 +: 8] = 8'h66;
    exp_wr[7*8 +: 8] = 8'h77;
    chk_wr("R12 update applied during stream");
    put(8'h01, 1'b1, 1'b0);
    put(8'd1, 1'b0, 1'b0);
    put(8'd1, 1'b0, 1'b0);
    put(8'd3, 1'b0, 1'b0);
    in_valid = 1'b1; in_data = 8'd4; in_eop = 1'b1;
    @(negedge clk);
    chk("R12 setup end held during stream", in_ready, 0);
    @(posedge clk); #2;
    out_ready = 1'b1;
    do begin
      @(negedge clk); r = in_ready;
      @(posedge clk); #2;
    end while (!r);
    in_valid = 1'b0; in_eop = 1'b0;
    repeat (6) @(posedge clk);
    #2;
    check_rx("R11 single stream despite second request", '{8'h45, 8'h40, 8'h00});
    expect_read("R12 held setup taken afterwards", '{8'h43});
  endtask

  task automatic t_dup_and_range();
    send('{8'h01, 8'd0, 8'd2, 8'd9, 8'd9});
    expect_none("R5 zero sample count");
    send('{8'h02, 8'hA1, 8'hB2});
    exp_wr[9*8 +: 8] = 8'hB2;
    chk_wr("R7 later slot wins");
    send('{8'h01, 8'd0, 8'd1, 8'hC8});
    send('{8'h02, 8'hCC});
    chk_wr("R7 out-of-range address skipped");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_data = 8'h00; in_sop = 1'b0; in_eop = 1'b0;
    out_ready = 1'b1;
    exp_wr = '0;
    for (int r = 0; r < NRD; r++) rd_regs[r*8 +: 8] = 8'h40 + 8'(r);
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_before_setup();
    t_bad_setup();
    t_setup_read();
    t_update_atomic();
    t_update_wrong_len();
    t_kind_and_abort();
    t_reuse();
    t_backpressure();
    t_overlap();
    t_dup_and_range();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule